// File: doc/BRIEF.md
# Run-time Configurable Sinc Decimator

This block turns a one-bit delta-sigma bitstream into signed multi-bit samples. Every accepted input bit counts as +1 or -1. The bits run through a cascade of up to three integrators, then are decimated. The comb section then rebuilds a sinc response of order one, two or three. A fourth structure code selects a fast variant. It uses the third-order response and does not discard the early outputs while the filter settles.

The structure code, the offset-by-one decimation field and the enable bit are plain inputs sampled every cycle. When any of them changes, or enable goes low, the filter drops its accumulated state and starts over. The sample strobe marks the clock cycles that carry a modulator bit. An output word comes with a single-cycle valid pulse once per decimation period.

Top module: `sinc_decim`

## Requirements
- R1: With structure code 01, 10 or 11 (order k = 1, 2, 3), a settled output for an all-ones input is +R^k and for an all-zeros input is -R^k, where R is the decimation ratio.
- R2: Structure code 00 uses the third-order gain and suppresses no output. For an all-ones input after a restart, the first output is R(R+1)(R+2)/6 and the third output is R^3.
- R3: R equals the 8-bit ratio field plus one, so fields 0 to 255 give ratios 1 to 256. One decimation happens every R accepted strobes. Valid goes high, for one cycle, in the cycle after the strobe that completes a period.
- R4: While enable is 0, no valid pulse is produced and strobes are ignored.
- R5: A change of the structure code or the ratio field, or a low enable, clears every integrator and comb register and the strobe counter. Counting then begins again at the next accepted strobe.
- R6: For orders 1 to 3, the first k-1 decimations after a restart produce no valid pulse. The first valid pulse follows strobe number k·R.
- R7: Input bit 1 counts as +1 and bit 0 as -1. An alternating input with an even ratio gives a settled output of 0 for orders 1 and 2.
- R8: After reset, the output word is 0 and valid is 0. The output word keeps the last emitted value until the next valid pulse, through suppressed decimations and restarts.
- R9: All accumulators are 26 bits and wrap modulo 2^26. Third order at ratio 256 gives exactly 2^24 for an all-ones input, even after the integrators have wrapped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_in | input | 1 | Modulator bit, taken when samp_en is high |
| samp_en | input | 1 | Strobe marking a modulator sample |
| ratio_m1 | input | 8 | Decimation ratio minus one |
| struct_sel | input | 2 | Filter structure code (00 fast, 01/10/11 order 1/2/3) |
| enable | input | 1 | Filter enable |
| dout | output | 26 | Signed decimated sample |
| dout_vld | output | 1 | One-cycle valid pulse for dout |

## Verification
Constant all-ones and all-zeros streams pin down the sign mapping and the R^k gain of each order. Run at several ratios, including 1 and 256, they also show the decimation spacing and where the first output lands. An alternating stream at an even ratio must cancel to zero, which separates a true sinc response from a plain counter of ones. Restart runs change the configuration in mid-period and drop enable. They show that the state is cleared and the count starts over, and that the held output word survives suppressed decimations.

// File: rtl/sinc_pkg.sv
package sinc_pkg;
    typedef enum logic [1:0] {
        STRUCT_FAST = 2'b00,
        STRUCT_O1   = 2'b01,
        STRUCT_O2   = 2'b10,
        STRUCT_O3   = 2'b11
    } sinc_struct_e;

    localparam int unsigned MAX_STAGES = 3;

    // number of active integrator/comb stages
    function automatic logic [1:0] active_stages(input logic [1:0] code);
        return (code == STRUCT_FAST) ? 2'd3 : code;
    endfunction

    // decimations discarded after restart
    function automatic logic [1:0] settle_need(input logic [1:0] code);
        return (code == STRUCT_FAST) ? 2'd0 : code - 2'd1;
    endfunction
endpackage

// File: rtl/sinc_ctrl.sv
module sinc_ctrl
    import sinc_pkg::*;
#(
    parameter int unsigned RATIO_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               samp_en,
    input  logic               enable,
    input  logic [RATIO_W-1:0] ratio_m1,
    input  logic [1:0]         struct_sel,
    output logic               restart,
    output logic               fire,
    output logic               emit,
    output logic [1:0]         stages,
    output logic               vld
);
    typedef struct packed {
        logic [RATIO_W-1:0] ratio;
        logic [1:0]         code;
        logic [RATIO_W-1:0] cnt;
        logic [1:0]         settle;
        logic               vld;
    } ctrl_t;

    ctrl_t cur_q, nxt_d;

    always_comb begin
        restart = !enable || (ratio_m1 != cur_q.ratio) || (struct_sel != cur_q.code);
        fire    = samp_en && !restart && (cur_q.cnt == ratio_m1);
        emit    = cur_q.settle >= settle_need(struct_sel);
        stages  = active_stages(struct_sel);

        nxt_d       = cur_q;
        nxt_d.ratio = ratio_m1;
        nxt_d.code  = struct_sel;
        nxt_d.vld   = fire && emit;
        if (restart) begin
            nxt_d.cnt    = '0;
            nxt_d.settle = '0;
        end else if (samp_en) begin
            nxt_d.cnt = fire ? '0 : cur_q.cnt + 1'b1;
            if (fire && !emit) nxt_d.settle = cur_q.settle + 2'd1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign vld = cur_q.vld;

    assert_vld_needs_enable_R4: assert property (@(posedge clk) disable iff (!rst_n)
        vld |-> $past(enable));
    assert_vld_after_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
        vld |-> $past(samp_en));
    assert_cnt_in_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cur_q.cnt <= cur_q.ratio);
    assert_settle_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cur_q.settle <= 2'd2);
endmodule

// File: rtl/sinc_integ.sv
module sinc_integ
    import sinc_pkg::*;
#(
    parameter int unsigned ACC_W = 26
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             step,
    input  logic             bit_in,
    input  logic [1:0]       stages,
    output logic [ACC_W-1:0] tap
);
    typedef struct packed {
        logic [MAX_STAGES-1:0][ACC_W-1:0] acc;
    } integ_t;

    integ_t cur_q, nxt_d;
    logic [MAX_STAGES-1:0][ACC_W-1:0] upd;

    always_comb begin
        logic [ACC_W-1:0] carry;
        carry = bit_in ? ACC_W'(1) : '1;  // +1 / -1
        nxt_d = cur_q;
        for (int i = 0; i < MAX_STAGES; i++) begin
            carry  = cur_q.acc[i] + carry;
            upd[i] = carry;
            if (step) nxt_d.acc[i] = carry;
        end
        if (clr) nxt_d = '0;
        tap = upd[stages - 2'd1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assert_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(clr) |-> (cur_q.acc == '0));
    assert_idle_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(step) && !$past(clr)) |-> $stable(cur_q.acc));
endmodule

// File: rtl/sinc_comb.sv
module sinc_comb
    import sinc_pkg::*;
#(
    parameter int unsigned ACC_W = 26
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             load,
    input  logic             emit,
    input  logic [1:0]       stages,
    input  logic [ACC_W-1:0] din,
    output logic [ACC_W-1:0] dout
);
    typedef struct packed {
        logic [MAX_STAGES-1:0][ACC_W-1:0] prev;
        logic [ACC_W-1:0]                 out;
    } comb_t;

    comb_t cur_q, nxt_d;

    always_comb begin
        logic [ACC_W-1:0] s;
        s     = din;
        nxt_d = cur_q;
        for (int i = 0; i < MAX_STAGES; i++) begin
            if (load) nxt_d.prev[i] = s;
            if (i < int'(stages)) s = s - cur_q.prev[i];
        end
        if (load && emit) nxt_d.out = s;
        if (clr) nxt_d.prev = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign dout = cur_q.out;

    assert_out_only_on_emit_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !($past(load) && $past(emit)) |-> $stable(cur_q.out));
endmodule

// File: rtl/sinc_decim.sv
module sinc_decim
    import sinc_pkg::*;
#(
    parameter int unsigned RATIO_W = 8,
    localparam int unsigned ACC_W  = MAX_STAGES * RATIO_W + 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    bit_in,
    input  logic                    samp_en,
    input  logic [RATIO_W-1:0]      ratio_m1,
    input  logic [1:0]              struct_sel,
    input  logic                    enable,
    output logic signed [ACC_W-1:0] dout,
    output logic                    dout_vld
);
    logic             restart, fire, emit;
    logic [1:0]       stages;
    logic [ACC_W-1:0] tap, comb_out;

    sinc_ctrl #(.RATIO_W(RATIO_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .samp_en(samp_en), .enable(enable),
        .ratio_m1(ratio_m1), .struct_sel(struct_sel), .restart(restart),
        .fire(fire), .emit(emit), .stages(stages), .vld(dout_vld)
    );

    sinc_integ #(.ACC_W(ACC_W)) u_integ (
        .clk(clk), .rst_n(rst_n), .clr(restart), .step(samp_en && !restart),
        .bit_in(bit_in), .stages(stages), .tap(tap)
    );

    sinc_comb #(.ACC_W(ACC_W)) u_comb (
        .clk(clk), .rst_n(rst_n), .clr(restart), .load(fire), .emit(emit),
        .stages(stages), .din(tap), .dout(comb_out)
    );

    assign dout = $signed(comb_out);

    assert_dout_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !dout_vld |-> $stable(dout));
endmodule

// File: tb/sinc_decim_tb.sv
module sinc_decim_tb;
    logic clk = 0, rst_n = 0, bit_in = 0, samp_en = 0, enable = 0;
    logic [7:0] ratio_m1 = 0;
    logic [1:0] struct_sel = 0;
    logic signed [25:0] dout;
    logic dout_vld;
    int n_chk = 0, n_fail = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    sinc_decim u_dut (.clk(clk), .rst_n(rst_n), .bit_in(bit_in), .samp_en(samp_en),
        .ratio_m1(ratio_m1), .struct_sel(struct_sel), .enable(enable),
        .dout(dout), .dout_vld(dout_vld));

    // {code[2], ratio_m1[8], pattern[2] (0 zeros, 1 ones, 2 alternating), expected[26]}
    localparam logic [37:0] VEC [8] = '{
        {2'b01, 8'd7,   2'd1, 26'sd8},
        {2'b01, 8'd7,   2'd0, -26'sd8},
        {2'b10, 8'd9,   2'd1, 26'sd100},
        {2'b11, 8'd4,   2'd0, -26'sd125},
        {2'b11, 8'd255, 2'd1, 26'sd16777216},
        {2'b10, 8'd3,   2'd2, 26'sd0},
        {2'b01, 8'd0,   2'd1, 26'sd1},
        {2'b11, 8'd15,  2'd1, 26'sd4096}
    };

    task automatic chk(string req, longint act, longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // one strobe; vld/dout observed one cycle later
    task automatic strobe(input logic b, output logic v, output longint d);
        @(negedge clk); samp_en = 1; bit_in = b;
        @(negedge clk); samp_en = 0; v = dout_vld; d = longint'(dout);
    endtask

    task automatic configure(input logic [1:0] c, input logic [7:0] r);
        @(negedge clk); enable = 0;
        @(negedge clk); struct_sel = c; ratio_m1 = r; enable = 1;
        @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic v; longint d, held;
        repeat (3) @(negedge clk);
        chk("R8 reset vld", dout_vld, 0);
        chk("R8 reset dout", dout, 0);
        rst_n = 1;

        // R1 R3 R6 R7 R9 vector walk
        for (int k = 0; k < 8; k++) begin
            logic [1:0] c; logic [7:0] r; logic [1:0] p; longint e;
            int rr, need, nv, first_s, second_s; longint val2;
            {c, r, p} = VEC[k][37:26];
            e = longint'($signed(VEC[k][25:0]));
            rr = int'(r) + 1; need = int'(c) - 1;
            nv = 0; first_s = 0; second_s = 0; val2 = 0;
            configure(c, r);
            for (int s = 1; s <= (need + 2) * rr; s++) begin
                strobe(p == 2 ? logic'(s % 2) : p[0], v, d);
                if (v) begin
                    nv++;
                    if (nv == 1) first_s = s;
                    if (nv == 2) begin second_s = s; val2 = d; end
                end
            end
            chk($sformatf("R6 first valid strobe vec%0d", k), first_s, (need + 1) * rr);
            chk($sformatf("R3 spacing vec%0d", k), second_s - first_s, rr);
            chk($sformatf("R1/R7/R9 value vec%0d", k), val2, e);
        end

        // R2 fast variant, ratio 4, all ones
        begin
            int nv = 0;
            configure(2'b00, 8'd3);
            for (int s = 1; s <= 12; s++) begin
                strobe(1'b1, v, d);
                if (v) begin
                    nv++;
                    if (nv == 1) begin chk("R2 first at strobe 4", s, 4); chk("R2 first value", d, 20); end
                    if (nv == 3) chk("R2 third value", d, 64);
                end
            end
            chk("R2 valid count", nv, 3);
        end

        // R4 disabled: no valid, dout untouched
        held = longint'(dout);
        begin
            int nv = 0;
            @(negedge clk); enable = 0;
            for (int s = 0; s < 20; s++) begin strobe(1'b1, v, d); if (v) nv++; end
            chk("R4 no valid while disabled", nv, 0);
            chk("R8 dout held while disabled", dout, held);
        end

        // R5 re-enable after drop: order 1 ratio 4 (ratio_m1 3)
        @(negedge clk); struct_sel = 2'b01; ratio_m1 = 8'd3; enable = 1;
        @(negedge clk);
        begin
            int fs = 0;
            for (int s = 1; s <= 4; s++) begin strobe(1'b1, v, d); if (v && fs == 0) begin fs = s; held = d; end end
            chk("R5 restart after enable first valid", fs, 4);
            chk("R5 restart after enable value", held, 4);
        end

        // R5 ratio change mid-period: ratio 8 for 5 strobes, then ratio 4
        configure(2'b01, 8'd7);
        for (int s = 0; s < 5; s++) strobe(1'b1, v, d);
        @(negedge clk); ratio_m1 = 8'd3;
        @(negedge clk);
        begin
            int fs = 0;
            for (int s = 1; s <= 4; s++) begin strobe(1'b0, v, d); if (v && fs == 0) begin fs = s; held = d; end end
            chk("R5 ratio change first valid", fs, 4);
            chk("R5 ratio change value", held, -4);
        end

        // R8 R6: order 3 ratio 2, two suppressed decimations keep dout
        @(negedge clk); struct_sel = 2'b11; ratio_m1 = 8'd1;
        @(negedge clk);
        begin
            int nv = 0;
            for (int s = 0; s < 4; s++) begin
                strobe(1'b1, v, d);
                if (v) nv++;
                chk("R8 dout held over suppressed", d, held);
            end
            chk("R6 suppressed count", nv, 0);
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule